// File: doc/BRIEF.md
# Serial Packet Input Receiver

This block sits on one input port of a multi-port router. It samples a single serial data line and two active-low strobes, frame and valid, once per clock. It decodes each packet into a destination address and a stream of payload bytes. A packet opens when frame falls. Four address bits follow, least significant first. After them come five filler clocks, whose contents the receiver ignores. The payload then arrives as bytes, each sent bit 0 first, with valid held low on every bit that counts. The sender marks the end of the packet by raising frame on bit 7 of the last byte. No length field is used.

Each finished byte leaves the block on a parallel output with a one-clock strobe. The destination and two markers travel with it: one for the first byte of the packet and one for the last. The serial line cannot be paused, so the output side has no ready signal. The consumer must take every strobe in the cycle it appears. Strobes are always at least eight clocks apart. A packet whose frame rises too early is dropped, and whatever it had not yet delivered is lost.

Top module: `serpkt_rx`

## Requirements
- R1: While reset is low and after it is released, the outputs rx_valid, rx_first and rx_last are 0 and rx_dest and rx_byte are 0, until a byte is delivered.
- R2: In idle, the first clock on which frame_n is sampled low carries destination bit 0. The next three clocks carry bits 1 to 3. valid_n has no effect during these four clocks.
- R3: Exactly five clocks after the address are skipped. Their din and valid_n values do not affect the delivered bytes.
- R4: In the data phase a bit is taken only on a clock with valid_n low, into bit positions 0 to 7 in order. A clock with valid_n high and frame_n low adds no bit.
- R5: rx_valid is high for exactly one clock, starting on the clock after the edge that takes bit 7. rx_byte and rx_dest hold that byte and its packet's address during that clock.
- R6: rx_first is 1 with the first byte of every packet and 0 with all other bytes.
- R7: rx_last is 1 with a byte when frame_n was high on its bit 7. The receiver is then idle, and a new packet may start on the very next clock.
- R8: frame_n high during the address or skip clocks drops the packet. No byte is produced, and rx_dest keeps its earlier value.
- R9: In the data phase, frame_n high on any clock that does not take bit 7 drops the rest of the packet. Bytes already delivered stand, the partial byte is discarded, and no rx_last is raised.
- R10: rx_dest changes only together with a delivered byte. It is the same for every byte of one packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; inputs are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 1 | Serial data line |
| frame_n | input | 1 | Active-low packet frame |
| valid_n | input | 1 | Active-low data-bit qualifier |
| rx_dest | output | 4 | Destination address of the delivered byte |
| rx_byte | output | 8 | Delivered payload byte |
| rx_valid | output | 1 | One-clock strobe for a delivered byte |
| rx_first | output | 1 | Delivered byte is the packet's first |
| rx_last | output | 1 | Delivered byte is the packet's last |

## Verification
If the phase counter is off by even one clock, the header and the payload slide against each other. The first delivered byte then shows the wrong address or a byte shifted by one bit, already eight clocks into the payload. If the controller is stuck in a phase, or fails to leave it after frame rises, the symptom is either a missing strobe or a strobe from a packet that should have been dropped. The scoreboard reports it as an unexpected or missing byte no later than the end of that packet. A wrong first-byte flag can only be seen on the first byte after a drop or after a back-to-back start. The bench stages both of those situations.

// File: rtl/serpkt_rx_pkg.sv
`timescale 1ns/1ps
package serpkt_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_PAD  = 2'd2,
    ST_DATA = 2'd3
  } rx_state_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/serpkt_rx_ctrl.sv
`timescale 1ns/1ps
module serpkt_rx_ctrl
  import serpkt_rx_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int PAD_LEN = 5,
  parameter int BYTE_W  = 8,
  localparam int CNT_W  = $clog2(max3(ADDR_W, PAD_LEN, BYTE_W))
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic             valid_n,
  output logic             addr_we,
  output logic             bit_we,
  output logic             byte_done,
  output logic             byte_last,
  output logic             byte_first,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] ADDR_END = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] PAD_END  = CNT_W'(PAD_LEN - 1);
  localparam logic [CNT_W-1:0] BIT_END  = CNT_W'(BYTE_W - 1);

  rx_state_t        state, st_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             first_q, first_n;

  assign cnt_o      = cnt;
  assign byte_first = first_q;
  assign addr_we    = (state == ST_IDLE || state == ST_ADDR) && !frame_n;
  assign byte_done  = (state == ST_DATA) && !valid_n && (cnt == BIT_END);
  assign byte_last  = byte_done && frame_n;
  assign bit_we     = (state == ST_DATA) && !valid_n && (!frame_n || cnt == BIT_END);

  always_comb begin
    st_n    = state;
    cnt_n   = cnt;
    first_n = first_q;
    unique case (state)
      ST_IDLE: if (!frame_n) begin
        st_n  = ST_ADDR;
        cnt_n = CNT_W'(1);
      end
      ST_ADDR: begin
        if (frame_n) begin
          st_n  = ST_IDLE;
          cnt_n = '0;
        end else if (cnt == ADDR_END) begin
          st_n  = ST_PAD;
          cnt_n = '0;
        end else begin
          cnt_n = cnt + CNT_W'(1);
        end
      end
      ST_PAD: begin
        if (frame_n) begin
          st_n  = ST_IDLE;
          cnt_n = '0;
        end else if (cnt == PAD_END) begin
          st_n    = ST_DATA;
          cnt_n   = '0;
          first_n = 1'b1;
        end else begin
          cnt_n = cnt + CNT_W'(1);
        end
      end
      ST_DATA: begin
        if (!valid_n) begin
          if (cnt == BIT_END) begin
            cnt_n   = '0;
            first_n = 1'b0;
            if (frame_n) st_n = ST_IDLE;
          end else if (frame_n) begin
            st_n  = ST_IDLE;
            cnt_n = '0;
          end else begin
            cnt_n = cnt + CNT_W'(1);
          end
        end else if (frame_n) begin
          st_n  = ST_IDLE;
          cnt_n = '0;
        end
      end
      default: begin
        st_n  = ST_IDLE;
        cnt_n = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      first_q <= 1'b0;
    end else begin
      state   <= st_n;
      cnt     <= cnt_n;
      first_q <= first_n;
    end
  end

  // R3: payload phase is only ever entered from the skip phase
  p_data_after_pad_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && $past(state) != ST_DATA) |-> $past(state) == ST_PAD);

  // R8: early frame release in the header returns to idle
  p_header_cut_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_ADDR || state == ST_PAD) && frame_n) |=> state == ST_IDLE);

  // R4: a stall clock neither advances nor leaves the data phase
  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && valid_n && !frame_n) |=> (state == ST_DATA && $stable(cnt)));
endmodule

// File: rtl/serpkt_rx_dp.sv
`timescale 1ns/1ps
module serpkt_rx_dp #(
  parameter int ADDR_W = 4,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 3,
  localparam int AIDX_W = (ADDR_W > 1) ? $clog2(ADDR_W) : 1,
  localparam int BIDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din,
  input  logic              addr_we,
  input  logic              bit_we,
  input  logic              byte_done,
  input  logic              byte_last,
  input  logic              byte_first,
  input  logic [CNT_W-1:0]  cnt,
  output logic [ADDR_W-1:0] rx_dest,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic              rx_first,
  output logic              rx_last
);
  logic [ADDR_W-1:0] dest_sh;
  logic [BYTE_W-1:0] byte_sh, byte_nx;
  logic [AIDX_W-1:0] aidx;
  logic [BIDX_W-1:0] bidx;

  assign aidx = cnt[AIDX_W-1:0];
  assign bidx = cnt[BIDX_W-1:0];

  always_comb begin
    byte_nx = byte_sh;
    if (bit_we) byte_nx[bidx] = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_sh  <= '0;
      byte_sh  <= '0;
      rx_dest  <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
      rx_first <= 1'b0;
      rx_last  <= 1'b0;
    end else begin
      if (addr_we) dest_sh[aidx] <= din;
      byte_sh  <= byte_nx;
      rx_valid <= byte_done;
      rx_first <= byte_done && byte_first;
      rx_last  <= byte_last;
      if (byte_done) begin
        rx_byte <= byte_nx;
        rx_dest <= dest_sh;
      end
    end
  end

  // R5: strobes can never be adjacent
  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R10: destination holds across the bytes of one packet
  p_dest_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_first) |-> $stable(rx_dest));
endmodule

// File: rtl/serpkt_rx.sv
`timescale 1ns/1ps
module serpkt_rx
  import serpkt_rx_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int PAD_LEN = 5,
  parameter int BYTE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din,
  input  logic              frame_n,
  input  logic              valid_n,
  output logic [ADDR_W-1:0] rx_dest,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic              rx_first,
  output logic              rx_last
);
  localparam int CNT_W = $clog2(max3(ADDR_W, PAD_LEN, BYTE_W));

  logic             addr_we, bit_we, byte_done, byte_last, byte_first;
  logic [CNT_W-1:0] cnt;

  serpkt_rx_ctrl #(
    .ADDR_W(ADDR_W), .PAD_LEN(PAD_LEN), .BYTE_W(BYTE_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .valid_n(valid_n),
    .addr_we(addr_we), .bit_we(bit_we), .byte_done(byte_done),
    .byte_last(byte_last), .byte_first(byte_first), .cnt_o(cnt)
  );

  serpkt_rx_dp #(
    .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .din(din),
    .addr_we(addr_we), .bit_we(bit_we), .byte_done(byte_done),
    .byte_last(byte_last), .byte_first(byte_first), .cnt(cnt),
    .rx_dest(rx_dest), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .rx_first(rx_first), .rx_last(rx_last)
  );

  // R1: no flag without a strobe
  p_flags_need_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_first || rx_last) |-> rx_valid);
endmodule

// File: tb/serpkt_rx_tb.sv
`timescale 1ns/1ps
module serpkt_rx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       din = 1'b0;
  logic       frame_n = 1'b1;
  logic       valid_n = 1'b1;
  logic [3:0] rx_dest;
  logic [7:0] rx_byte;
  logic       rx_valid, rx_first, rx_last;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [3:0] d;
    logic [7:0] b;
    bit         f;
    bit         l;
    string      req;
  } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  serpkt_rx u_dut (
    .clk(clk), .rst_n(rst_n), .din(din), .frame_n(frame_n), .valid_n(valid_n),
    .rx_dest(rx_dest), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .rx_first(rx_first), .rx_last(rx_last)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic drive(input bit d, input bit f, input bit v);
    @(negedge clk);
    din = d; frame_n = f; valid_n = v;
  endtask

  task automatic idle();
    drive(1'b0, 1'b1, 1'b1);
  endtask

  // cut_addr / cut_pad: clock index where frame rises early (-1 = none)
  // cut_byte / cut_bit: data bit where frame rises early (-1 = none)
  task automatic send_pkt(input logic [3:0] dest, input int nbytes, input int base,
                          input bit stall, input int cut_addr, input int cut_pad,
                          input int cut_byte, input int cut_bit, input bit gap,
                          input string req);
    for (int i = 0; i < 4; i++) begin
      if (i == cut_addr) begin idle(); return; end
      drive(dest[i], 1'b0, i[0]);
    end
    for (int i = 0; i < 5; i++) begin
      if (i == cut_pad) begin idle(); return; end
      drive((i == 2) ? 1'b0 : 1'b1, 1'b0, (i == 3) ? 1'b0 : 1'b1);
    end
    for (int b = 0; b < nbytes; b++) begin
      logic [7:0] byt;
      byt = 8'((base + b * 37) & 255);
      for (int k = 0; k < 8; k++) begin
        bit lastbit;
        if (stall && k == 3) drive(~byt[k], 1'b0, 1'b1);
        if (b == cut_byte && k == cut_bit) begin
          drive(byt[k], 1'b1, 1'b0);
          idle();
          return;
        end
        lastbit = (b == nbytes - 1) && (k == 7);
        if (k == 7) exp_q.push_back('{dest, byt, b == 0, b == nbytes - 1, req});
        drive(byt[k], lastbit, 1'b0);
      end
    end
    if (gap) idle();
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done && rx_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8", "unexpected byte", rx_byte, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(rx_byte == e.b, e.req, "byte", rx_byte, e.b);
        chk(rx_dest == e.d, e.req, "dest R10", rx_dest, e.d);
        chk(rx_first == e.f, e.req, "first R6", rx_first, e.f);
        chk(rx_last == e.l, e.req, "last R7", rx_last, e.l);
      end
    end
  end

  task automatic drain(input string req);
    repeat (12) @(negedge clk);
    chk(exp_q.size() == 0, req, "missing bytes", exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!rx_valid && !rx_first && !rx_last, "R1", "flags in reset",
        {rx_valid, rx_first, rx_last}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(rx_dest == 4'd0 && rx_byte == 8'd0 && !rx_valid, "R1", "outputs after reset",
        {rx_dest, rx_byte, rx_valid}, 0);

    // single-byte packet: first and last together
    send_pkt(4'd5, 1, 8'h5a, 0, -1, -1, -1, -1, 1, "R5");
    drain("R5");
    // multi-byte, valid_n toggling in address, junk in skip clocks
    send_pkt(4'd10, 4, 8'h31, 0, -1, -1, -1, -1, 1, "R2");
    drain("R3");
    // stall clocks mid-byte
    send_pkt(4'd15, 3, 8'hc4, 1, -1, -1, -1, -1, 1, "R4");
    drain("R4");
    // drop in address phase
    send_pkt(4'd3, 2, 8'h11, 0, 2, -1, -1, -1, 1, "R8");
    drain("R8");
    chk(rx_dest == 4'd15, "R8", "dest after address drop", rx_dest, 15);
    // drop in skip phase
    send_pkt(4'd6, 2, 8'h22, 0, -1, 4, -1, -1, 1, "R8");
    drain("R8");
    chk(rx_dest == 4'd15, "R8", "dest after skip drop", rx_dest, 15);
    // drop mid-data: two bytes delivered, no last
    send_pkt(4'd9, 4, 8'h7e, 0, -1, -1, 2, 3, 1, "R9");
    drain("R9");
    // back-to-back packets with no idle gap
    send_pkt(4'd0, 32, 8'h01, 0, -1, -1, -1, -1, 0, "R7");
    send_pkt(4'd12, 2, 8'hf0, 0, -1, -1, -1, -1, 1, "R7");
    drain("R7");
    chk(!rx_valid, "R5", "strobe idle after traffic", rx_valid, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule